// File: doc/BRIEF.md
# Out-of-order reorder buffer with rename table

This block is the back end of a small out-of-order core. Instructions arrive in program order on a dispatch port. Each one takes the next reorder-buffer entry and one reservation-station slot. Its source registers are resolved through a rename table. Each table entry says either "the current value sits in the register file" or "the current value will come from reorder-buffer entry N". A source is captured as a ready value when possible. Otherwise the slot waits on the producer's tag.

Functional units are outside the block. An instruction with both operands ready is offered on the issue port, and the unit returns the result later on a completion port, addressed by reorder-buffer tag. That completion is broadcast to every waiting slot and marks the buffer entry done. Entries leave the buffer strictly from the head, one per cycle, and write the register file only at that point. A read port exposes the committed register file.

Top module: `rob_core`

## Requirements
- R1: After reset, register i of the register file reads NUM_AREG-i (6,5,4,3,2,1 for registers 0 to 5 with defaults). No commit and no issue are offered, and disp_ready is high.
- R2: An instruction is accepted in a cycle where disp_valid and disp_ready are both high. Accepted instructions get buffer tags 0,1,…,ROB_DEPTH-1 and then wrap to 0. Its tag is the one shown on issue_tag and expected back on cmpl_tag.
- R3: A source whose rename entry points at the register file is captured ready with the register-file value. This covers a register that was never written and one whose latest writer has already retired.
- R4: A source whose latest writer has completed but not yet retired takes its value from that writer's buffer entry.
- R5: A source whose writer has not completed waits on the writer's tag. A completion carrying that tag fills the operand. This includes a completion in the same cycle as the dispatch.
- R6: issue_valid offers a slot whose operands are both ready, with issue_op 0 for add and 1 for multiply. The slot is freed only in a cycle where issue_ready is high, and each instruction issues exactly once.
- R7: A completion marks its entry done. The head entry retires once it is done, at most one per cycle, in program order. A finished instruction never retires before an older unfinished one.
- R8: Retirement writes the value to the destination register. The rename entry reverts to the register file only if it still names the retiring tag, so a younger writer's mapping survives.
- R9: disp_ready is low whenever the buffer holds ROB_DEPTH entries or all RS_DEPTH slots are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Room in buffer and stations |
| disp_op | input | 1 | 0 add, 1 multiply |
| disp_pc | input | PC_W | Instruction address |
| disp_dst | input | AREG_W | Destination register |
| disp_src_a | input | AREG_W | First source register |
| disp_src_b | input | AREG_W | Second source register |
| issue_valid | output | 1 | A ready instruction is offered |
| issue_ready | input | 1 | Functional unit takes the offer |
| issue_op | output | 1 | Operation of the offered instruction |
| issue_tag | output | TAG_W | Buffer tag of the offered instruction |
| issue_a | output | DATA_W | First operand value |
| issue_b | output | DATA_W | Second operand value |
| cmpl_valid | input | 1 | Result returned |
| cmpl_tag | input | TAG_W | Tag of the returned result |
| cmpl_value | input | DATA_W | Result value |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_pc | output | PC_W | Address of the retiring instruction |
| commit_dst | output | AREG_W | Register written at retirement |
| commit_value | output | DATA_W | Value written at retirement |
| rd_addr | input | AREG_W | Register-file read address |
| rd_data | output | DATA_W | Committed register value |

## Verification
The bench uses the defaults: 6 registers, a 9-entry buffer, 5 station slots and 16-bit data. With an odd buffer depth, tag wraparound happens at a count that is not a power of two. Forty instructions wrap the tags several times. A ten-cycle multiply latency stalls the head long enough to fill all nine buffer entries. A window with issue_ready held low fills all five slots, so both stall sources of R9 are reached, and the register recycling in the short add/multiply program creates the younger-writer case of R8.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [0:0] {
      OP_ADD = 1'b0,
      OP_MUL = 1'b1
   } op_e;

   // number of source operands carried per instruction
   localparam int NSRC = 2;

endpackage

// File: rtl/rob_regs.sv
module rob_regs #(
   parameter int NUM_AREG = 6,
   parameter int DATA_W   = 16,
   parameter int TAG_W    = 4,
   parameter int AREG_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AREG_W-1:0] look_a,
   input  logic [AREG_W-1:0] look_b,
   output logic              busy_a,
   output logic              busy_b,
   output logic [TAG_W-1:0]  tag_a,
   output logic [TAG_W-1:0]  tag_b,
   output logic [DATA_W-1:0] val_a,
   output logic [DATA_W-1:0] val_b,
   input  logic              ren_we,
   input  logic [AREG_W-1:0] ren_dst,
   input  logic [TAG_W-1:0]  ren_tag,
   input  logic              ret_we,
   input  logic [AREG_W-1:0] ret_dst,
   input  logic [TAG_W-1:0]  ret_tag,
   input  logic [DATA_W-1:0] ret_val,
   input  logic [AREG_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic              busy_q [NUM_AREG];
   logic [TAG_W-1:0]  tag_q  [NUM_AREG];
   logic [DATA_W-1:0] arf_q  [NUM_AREG];

   assign busy_a  = busy_q[look_a];
   assign busy_b  = busy_q[look_b];
   assign tag_a   = tag_q[look_a];
   assign tag_b   = tag_q[look_b];
   assign val_a   = arf_q[look_a];
   assign val_b   = arf_q[look_b];
   assign rd_data = arf_q[rd_addr];

   // a rename in the same cycle is written last and so overrides the revert
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_AREG; r++) begin
            busy_q[r] <= 1'b0;
            tag_q[r]  <= '0;
            arf_q[r]  <= DATA_W'(NUM_AREG - r);
         end
      end else begin
         if (ret_we) begin
            arf_q[ret_dst] <= ret_val;
            if (busy_q[ret_dst] && tag_q[ret_dst] == ret_tag)
               busy_q[ret_dst] <= 1'b0;
         end
         if (ren_we) begin
            busy_q[ren_dst] <= 1'b1;
            tag_q[ren_dst]  <= ren_tag;
         end
      end
   end

   // R8
   rat_keep_newer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_we && busy_q[ret_dst] && tag_q[ret_dst] != ret_tag |=> busy_q[$past(ret_dst)]);

endmodule

// File: rtl/rob_buf.sv
module rob_buf #(
   parameter int DEPTH  = 9,
   parameter int DATA_W = 16,
   parameter int PC_W   = 16,
   parameter int AREG_W = 3,
   parameter int TAG_W  = 4,
   parameter int NQ     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [PC_W-1:0]   alloc_pc,
   input  logic [AREG_W-1:0] alloc_dst,
   output logic [TAG_W-1:0]  tail_tag,
   output logic              full,
   input  logic              cmpl_valid,
   input  logic [TAG_W-1:0]  cmpl_tag,
   input  logic [DATA_W-1:0] cmpl_val,
   input  logic [TAG_W-1:0]  q_tag [NQ],
   output logic              q_rdy [NQ],
   output logic [DATA_W-1:0] q_val [NQ],
   output logic              ret_valid,
   output logic [TAG_W-1:0]  ret_tag,
   output logic [PC_W-1:0]   ret_pc,
   output logic [AREG_W-1:0] ret_dst,
   output logic [DATA_W-1:0] ret_val
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

   logic              valid_q [DEPTH];
   logic              done_q  [DEPTH];
   logic [PC_W-1:0]   pc_q    [DEPTH];
   logic [AREG_W-1:0] dst_q   [DEPTH];
   logic [DATA_W-1:0] val_q   [DEPTH];
   logic [TAG_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  cnt_q;

   function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign tail_tag  = tail_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign ret_valid = valid_q[head_q] && done_q[head_q];
   assign ret_tag   = head_q;
   assign ret_pc    = pc_q[head_q];
   assign ret_dst   = dst_q[head_q];
   assign ret_val   = val_q[head_q];

   // operand lookups see a completion of the same cycle
   for (genvar g = 0; g < NQ; g++) begin : g_look
      logic hit;
      assign hit      = cmpl_valid && (cmpl_tag == q_tag[g]);
      assign q_rdy[g] = done_q[q_tag[g]] || hit;
      assign q_val[g] = hit ? cmpl_val : val_q[q_tag[g]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            valid_q[e] <= 1'b0;
            done_q[e]  <= 1'b0;
         end
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (alloc) begin
            valid_q[tail_q] <= 1'b1;
            done_q[tail_q]  <= 1'b0;
            tail_q          <= bump(tail_q);
         end
         if (cmpl_valid)
            done_q[cmpl_tag] <= 1'b1;
         if (ret_valid) begin
            valid_q[head_q] <= 1'b0;
            head_q          <= bump(head_q);
         end
         cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(ret_valid);
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) begin
         pc_q[tail_q]  <= alloc_pc;
         dst_q[tail_q] <= alloc_dst;
      end
      if (cmpl_valid)
         val_q[cmpl_tag] <= cmpl_val;
   end

   // R9
   alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full);
   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   // R7
   cmpl_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid |-> valid_q[cmpl_tag] && !done_q[cmpl_tag]);
   // R7
   head_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> head_q != $past(head_q));

endmodule

// File: rtl/rob_rs.sv
module rob_rs
   import rob_pkg::*;
#(
   parameter int DEPTH  = 5,
   parameter int DATA_W = 16,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins,
   input  op_e               ins_op,
   input  logic [TAG_W-1:0]  ins_dtag,
   input  logic              ins_rdy [NSRC],
   input  logic [TAG_W-1:0]  ins_tag [NSRC],
   input  logic [DATA_W-1:0] ins_val [NSRC],
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              has_room,
   output logic              iss_valid,
   input  logic              iss_ready,
   output op_e               iss_op,
   output logic [TAG_W-1:0]  iss_tag,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);

   localparam int IDX_W = $clog2(DEPTH);

   logic              busy_q [DEPTH];
   op_e               op_q   [DEPTH];
   logic [TAG_W-1:0]  dtag_q [DEPTH];
   logic              rdy_q  [DEPTH][NSRC];
   logic [TAG_W-1:0]  src_q  [DEPTH][NSRC];
   logic [DATA_W-1:0] val_q  [DEPTH][NSRC];
   logic [IDX_W-1:0]  free_idx, pick_idx;

   // lowest free slot for insertion, lowest ready slot for issue
   always_comb begin
      has_room  = 1'b0;
      free_idx  = '0;
      iss_valid = 1'b0;
      pick_idx  = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (!busy_q[e]) begin
            has_room = 1'b1;
            free_idx = IDX_W'(e);
         end
         if (busy_q[e] && rdy_q[e][0] && rdy_q[e][1]) begin
            iss_valid = 1'b1;
            pick_idx  = IDX_W'(e);
         end
      end
   end

   assign iss_op  = op_q[pick_idx];
   assign iss_tag = dtag_q[pick_idx];
   assign iss_a   = val_q[pick_idx][0];
   assign iss_b   = val_q[pick_idx][1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            busy_q[e] <= 1'b0;
            op_q[e]   <= OP_ADD;
            dtag_q[e] <= '0;
            for (int k = 0; k < NSRC; k++) begin
               rdy_q[e][k] <= 1'b0;
               src_q[e][k] <= '0;
               val_q[e][k] <= '0;
            end
         end
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            for (int k = 0; k < NSRC; k++) begin
               if (busy_q[e] && !rdy_q[e][k] && bc_valid && bc_tag == src_q[e][k]) begin
                  rdy_q[e][k] <= 1'b1;
                  val_q[e][k] <= bc_val;
               end
            end
            if (iss_valid && iss_ready && pick_idx == IDX_W'(e))
               busy_q[e] <= 1'b0;
            if (ins && free_idx == IDX_W'(e)) begin
               busy_q[e] <= 1'b1;
               op_q[e]   <= ins_op;
               dtag_q[e] <= ins_dtag;
               for (int k = 0; k < NSRC; k++) begin
                  rdy_q[e][k] <= ins_rdy[k];
                  src_q[e][k] <= ins_tag[k];
                  val_q[e][k] <= ins_val[k];
               end
            end
         end
      end
   end

   // R9
   rs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins |-> has_room);
   // R6
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && !iss_ready |=> iss_valid);

endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int NUM_AREG  = 6,
   parameter int ROB_DEPTH = 9,
   parameter int RS_DEPTH  = 5,
   parameter int DATA_W    = 16,
   parameter int PC_W      = 16,
   localparam int AREG_W   = $clog2(NUM_AREG),
   localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   output logic              disp_ready,
   input  logic              disp_op,
   input  logic [PC_W-1:0]   disp_pc,
   input  logic [AREG_W-1:0] disp_dst,
   input  logic [AREG_W-1:0] disp_src_a,
   input  logic [AREG_W-1:0] disp_src_b,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic              issue_op,
   output logic [TAG_W-1:0]  issue_tag,
   output logic [DATA_W-1:0] issue_a,
   output logic [DATA_W-1:0] issue_b,
   input  logic              cmpl_valid,
   input  logic [TAG_W-1:0]  cmpl_tag,
   input  logic [DATA_W-1:0] cmpl_value,
   output logic              commit_valid,
   output logic [PC_W-1:0]   commit_pc,
   output logic [AREG_W-1:0] commit_dst,
   output logic [DATA_W-1:0] commit_value,
   input  logic [AREG_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   if (NUM_AREG < 2 || ROB_DEPTH < 2 || RS_DEPTH < 2) begin : g_bad_depth
      $error("rob_core: register count and both depths must be at least 2");
   end
   if (DATA_W < 1 || PC_W < 1) begin : g_bad_width
      $error("rob_core: data and address widths must be positive");
   end

   logic              rob_full, rs_room, take;
   logic [TAG_W-1:0]  tail_tag, ret_tag;
   logic              rat_busy [NSRC];
   logic [TAG_W-1:0]  rat_tag  [NSRC];
   logic [DATA_W-1:0] arf_val  [NSRC];
   logic              rob_rdy  [NSRC];
   logic [DATA_W-1:0] rob_val  [NSRC];
   logic              op_rdy   [NSRC];
   logic [DATA_W-1:0] op_val   [NSRC];
   op_e               iss_op_e;

   assign disp_ready = !rob_full && rs_room;
   assign take       = disp_valid && disp_ready;
   assign issue_op   = iss_op_e;

   // source resolution: register file, finished buffer entry, or wait on tag
   for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign op_rdy[k] = !rat_busy[k] || rob_rdy[k];
      assign op_val[k] = !rat_busy[k] ? arf_val[k] : rob_val[k];
   end

   rob_regs #(
      .NUM_AREG(NUM_AREG), .DATA_W(DATA_W), .TAG_W(TAG_W), .AREG_W(AREG_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .look_a(disp_src_a), .look_b(disp_src_b),
      .busy_a(rat_busy[0]), .busy_b(rat_busy[1]),
      .tag_a(rat_tag[0]), .tag_b(rat_tag[1]),
      .val_a(arf_val[0]), .val_b(arf_val[1]),
      .ren_we(take), .ren_dst(disp_dst), .ren_tag(tail_tag),
      .ret_we(commit_valid), .ret_dst(commit_dst), .ret_tag(ret_tag), .ret_val(commit_value),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   rob_buf #(
      .DEPTH(ROB_DEPTH), .DATA_W(DATA_W), .PC_W(PC_W), .AREG_W(AREG_W),
      .TAG_W(TAG_W), .NQ(NSRC)
   ) buf_i (
      .clk(clk), .rst_n(rst_n),
      .alloc(take), .alloc_pc(disp_pc), .alloc_dst(disp_dst),
      .tail_tag(tail_tag), .full(rob_full),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_val(cmpl_value),
      .q_tag(rat_tag), .q_rdy(rob_rdy), .q_val(rob_val),
      .ret_valid(commit_valid), .ret_tag(ret_tag), .ret_pc(commit_pc),
      .ret_dst(commit_dst), .ret_val(commit_value)
   );

   rob_rs #(
      .DEPTH(RS_DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)
   ) rs_i (
      .clk(clk), .rst_n(rst_n),
      .ins(take), .ins_op(op_e'(disp_op)), .ins_dtag(tail_tag),
      .ins_rdy(op_rdy), .ins_tag(rat_tag), .ins_val(op_val),
      .bc_valid(cmpl_valid), .bc_tag(cmpl_tag), .bc_val(cmpl_value),
      .has_room(rs_room),
      .iss_valid(issue_valid), .iss_ready(issue_ready), .iss_op(iss_op_e),
      .iss_tag(issue_tag), .iss_a(issue_a), .iss_b(issue_b)
   );

   // R9
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rob_full |-> !disp_ready);

endmodule

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;

   localparam int N_INST  = 40;
   localparam int NREG    = 6;
   localparam int ROBN    = 9;
   localparam int RSN     = 5;
   localparam int MUL_LAT = 10;
   localparam int ADD_LAT = 1;
   localparam int WD_LIM  = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 1'b0, disp_ready, disp_op = 1'b0;
   logic [15:0] disp_pc = '0;
   logic [2:0]  disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
   logic        issue_valid, issue_ready = 1'b0, issue_op;
   logic [3:0]  issue_tag;
   logic [15:0] issue_a, issue_b;
   logic        cmpl_valid = 1'b0;
   logic [3:0]  cmpl_tag = '0;
   logic [15:0] cmpl_value = '0;
   logic        commit_valid;
   logic [15:0] commit_pc, commit_value;
   logic [2:0]  commit_dst;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;

   always #10 clk = ~clk;

   rob_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
      .disp_pc(disp_pc), .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
      .issue_tag(issue_tag), .issue_a(issue_a), .issue_b(issue_b),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
      .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_dst(commit_dst),
      .commit_value(commit_value), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // program and sequential reference
   bit          p_op  [N_INST];
   int          p_dst [N_INST];
   int          p_sa  [N_INST];
   int          p_sb  [N_INST];
   logic [15:0] e_a   [N_INST];
   logic [15:0] e_b   [N_INST];
   logic [15:0] e_r   [N_INST];
   bit          issued [N_INST];
   logic [15:0] ref_rf [NREG];
   int          tag_owner [ROBN];

   // outstanding functional-unit results
   bit          pd_v [16];
   int          pd_t [16];
   int          pd_due [16];
   logic [15:0] pd_val [16];

   initial begin
      bit [31:0] seed;
      int cyc, next_disp, next_cmt, inflight, rs_occ;
      seed = 32'h1234_5678;
      // dependent add/multiply chain first, then a pseudo-random stream
      p_op[0] = 0; p_dst[0] = 3; p_sa[0] = 3; p_sb[0] = 1;
      p_op[1] = 1; p_dst[1] = 1; p_sa[1] = 1; p_sb[1] = 4;
      p_op[2] = 0; p_dst[2] = 5; p_sa[2] = 3; p_sb[2] = 4;
      p_op[3] = 1; p_dst[3] = 2; p_sa[3] = 1; p_sb[3] = 3;
      p_op[4] = 0; p_dst[4] = 2; p_sa[4] = 2; p_sb[4] = 1;
      for (int i = 5; i < N_INST; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         p_op[i]  = seed[16];
         p_dst[i] = int'((seed >> 18) % 6);
         p_sa[i]  = int'((seed >> 22) % 6);
         p_sb[i]  = int'((seed >> 26) % 6);
      end
      for (int r = 0; r < NREG; r++) ref_rf[r] = 16'(NREG - r);
      for (int i = 0; i < N_INST; i++) issued[i] = 0;
      for (int j = 0; j < 16; j++) pd_v[j] = 0;
      for (int t = 0; t < ROBN; t++) tag_owner[t] = -1;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      for (int r = 0; r < NREG; r++) begin
         rd_addr = 3'(r);
         #1;
         chk(rd_data == 16'(NREG - r), "R1", "reset register value", int'(rd_data), NREG - r);
      end
      chk(disp_ready == 1'b1, "R1", "disp_ready after reset", int'(disp_ready), 1);
      chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
      chk(commit_valid == 1'b0, "R1", "commit_valid after reset", int'(commit_valid), 0);

      cyc = 0; next_disp = 0; next_cmt = 0; inflight = 0; rs_occ = 0;
      while (next_cmt < N_INST && cyc < WD_LIM) begin
         // R9 stall model compared every cycle
         chk(disp_ready == (inflight < ROBN && rs_occ < RSN), "R9", "disp_ready",
             int'(disp_ready), int'(inflight < ROBN && rs_occ < RSN));

         // retirement observed: R7 order, R8 value and destination
         if (commit_valid) begin
            chk(commit_pc == 16'(next_cmt * 4), "R7", "commit pc order", int'(commit_pc), next_cmt * 4);
            chk(int'(commit_dst) == p_dst[next_cmt], "R8", "commit destination", int'(commit_dst), p_dst[next_cmt]);
            chk(commit_value == e_r[next_cmt], "R8", "commit value", int'(commit_value), int'(e_r[next_cmt]));
            next_cmt++;
            inflight--;
         end

         // functional unit acceptance; a window with issue_ready low fills the stations
         issue_ready = !(cyc >= 30 && cyc < 45);
         if (issue_valid && issue_ready) begin
            int k;
            int slot;
            k = tag_owner[issue_tag];
            chk(k >= 0, "R2", "issue tag belongs to a dispatched instruction", int'(issue_tag), 0);
            if (k >= 0) begin
               chk(!issued[k], "R6", "instruction issued once", k, -1);
               chk(issue_op == p_op[k], "R6", "issue op code", int'(issue_op), int'(p_op[k]));
               // R3/R4/R5/R8 operand source: register file, finished entry or broadcast
               chk(issue_a == e_a[k], "R3/R4/R5/R8", "first operand", int'(issue_a), int'(e_a[k]));
               chk(issue_b == e_b[k], "R3/R4/R5/R8", "second operand", int'(issue_b), int'(e_b[k]));
               issued[k] = 1;
            end
            slot = -1;
            for (int j = 0; j < 16; j++) if (!pd_v[j] && slot < 0) slot = j;
            pd_v[slot]   = 1;
            pd_t[slot]   = int'(issue_tag);
            pd_due[slot] = cyc + (issue_op ? MUL_LAT : ADD_LAT);
            pd_val[slot] = issue_op ? 16'(issue_a * issue_b) : 16'(issue_a + issue_b);
            rs_occ--;
         end

         // dispatch in program order; R2 tags run 0..ROBN-1 and wrap
         disp_valid = 1'b0;
         if (next_disp < N_INST) begin
            disp_valid = 1'b1;
            disp_op    = p_op[next_disp];
            disp_pc    = 16'(next_disp * 4);
            disp_dst   = 3'(p_dst[next_disp]);
            disp_src_a = 3'(p_sa[next_disp]);
            disp_src_b = 3'(p_sb[next_disp]);
            if (disp_ready) begin
               e_a[next_disp] = ref_rf[p_sa[next_disp]];
               e_b[next_disp] = ref_rf[p_sb[next_disp]];
               e_r[next_disp] = p_op[next_disp] ? 16'(e_a[next_disp] * e_b[next_disp])
                                                : 16'(e_a[next_disp] + e_b[next_disp]);
               ref_rf[p_dst[next_disp]] = e_r[next_disp];
               tag_owner[next_disp % ROBN] = next_disp;
               next_disp++;
               inflight++;
               rs_occ++;
            end
         end

         // return the oldest due result
         cmpl_valid = 1'b0;
         begin
            int best;
            best = -1;
            for (int j = 0; j < 16; j++)
               if (pd_v[j] && pd_due[j] <= cyc && (best < 0 || pd_due[j] < pd_due[best])) best = j;
            if (best >= 0) begin
               cmpl_valid = 1'b1;
               cmpl_tag   = 4'(pd_t[best]);
               cmpl_value = pd_val[best];
               pd_v[best] = 0;
            end
         end

         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      disp_valid  = 1'b0;
      cmpl_valid  = 1'b0;
      issue_ready = 1'b0;

      // watchdog expiry counts as a failed check
      chk(next_cmt == N_INST, "R7", "all instructions retired before watchdog", next_cmt, N_INST);

      // R8 final committed register file
      for (int r = 0; r < NREG; r++) begin
         rd_addr = 3'(r);
         #1;
         chk(rd_data == ref_rf[r], "R8", "final register value", int'(rd_data), int'(ref_rf[r]));
      end
      @(negedge clk);
      chk(commit_valid == 1'b0, "R7", "no retirement once buffer is drained", int'(commit_valid), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule